// File: doc/BRIEF.md
# Sleep-exit clock start-up sequencer

This block decides when a small processor core may leave sleep and which clock it runs on once it is awake. The core announces sleep with a one-cycle command, and the block then asserts a hold signal that keeps the core stopped. A wake request starts a wake sequence. In that sequence a CPU start-up timer on the always-running internal clock and, where the primary oscillator is a crystal, an oscillator start-up counter on the primary clock both start in the same cycle and count side by side.

The value of the clock-select input when the wake is accepted fixes the outcome. The block never changes this bit, so it keeps across sleep whatever value software left in it. With select high the core comes back on the internal oscillator as soon as the CPU timer expires. With select low and a crystal mode, the core stays held until both timers have expired and then runs on the primary clock. If two-speed start-up or the fail-safe monitor is enabled, the core is released after the CPU timer alone, runs on the internal clock, and moves to the primary clock once the oscillator counter has finished. The done flag of the oscillator counter reaches the internal-clock domain through a two-flop synchronizer. A status output shows when the primary clock is in use.

Top module: `sleep_clk_seq`

## Requirements
- R1: After reset, hold_sleep is 0, sys_clk_sel is 1 (1 = internal oscillator, 0 = primary clock) and pri_stable is 0.
- R2: A sleep_cmd pulse while the core is awake sets hold_sleep in the next cycle. While hold_sleep is 1, sys_clk_sel keeps its value, including when clk_sel_bit was cleared just before sleep.
- R3: If clk_sel_bit is 1 at the accepting edge, hold_sleep falls exactly CPU_CYCLES internal-clock cycles after that edge, with sys_clk_sel = 1 and pri_stable = 0.
- R4: If clk_sel_bit is 0, osc_mode is a crystal code (0, 1 or 2) and both bypass enables are 0, hold_sleep falls only after at least OST_CYCLES primary-clock rising edges since the accepting edge, and no more than 8 edges later. At exit sys_clk_sel = 0 and pri_stable = 1.
- R5: If clk_sel_bit is 0, osc_mode is a crystal code and two_speed_en or fail_safe_en is 1, hold_sleep falls exactly CPU_CYCLES cycles after the accepting edge with sys_clk_sel = 1 and pri_stable = 0. Later, within the R4 edge window, sys_clk_sel goes to 0 and pri_stable goes to 1.
- R6: If clk_sel_bit is 0 and osc_mode is 3 to 7 (a clock that is not a crystal), no oscillator count is made. hold_sleep falls exactly CPU_CYCLES cycles after the accepting edge, with sys_clk_sel = 0 and pri_stable = 1.
- R7: pri_stable reads 0 in the cycle after a wake request is accepted.
- R8: A wake_req while a wake sequence is running does not restart or shorten it. A wake_req while the core is awake leaves hold_sleep at 0 and sys_clk_sel unchanged.
- R9: Changes to clk_sel_bit, osc_mode or the enables after the accepting edge do not affect the sequence that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Always-running internal oscillator clock |
| clk_pri | input | 1 | Primary oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_cmd | input | 1 | One-cycle pulse: the core executes a sleep |
| wake_req | input | 1 | Wake request (interrupt or reset-free wake event) |
| clk_sel_bit | input | 1 | Software clock select: 1 = internal, 0 = primary |
| osc_mode | input | 3 | Primary oscillator mode, codes 0-2 are crystal modes |
| two_speed_en | input | 1 | Two-speed start-up enable |
| fail_safe_en | input | 1 | Fail-safe clock monitor enable |
| hold_sleep | output | 1 | 1 holds the core in sleep |
| sys_clk_sel | output | 1 | Clock the core uses: 1 = internal, 0 = primary |
| pri_stable | output | 1 | 1 once the primary clock is in use |

## Verification
The results that depend only on the CPU timer are due at a fixed cycle. hold_sleep must still be 1 on the falling edge after internal edge CPU_CYCLES-1, counted from the edge that accepts the wake, and must be 0 on the falling edge after edge CPU_CYCLES. The bench samples exactly those two points. The sync hops in both directions let the oscillator-dependent results land a few cycles either way, so the bench counts primary-clock edges from the wake and requires the release, or the move to the primary clock, to fall within a window of OST_CYCLES to OST_CYCLES+8 edges. The sleep hold and the clearing of the status bit are due one cycle after the command or request, and the bench samples them on the next falling edge.

// File: rtl/sleep_clk_pkg.sv
package sleep_clk_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE    = 2'd0,
        ST_ASLEEP   = 2'd1,
        ST_WAKE     = 2'd2,
        ST_INT_PEND = 2'd3
    } seq_state_e;

    localparam logic [2:0] MODE_LP = 3'd0;
    localparam logic [2:0] MODE_XT = 3'd1;
    localparam logic [2:0] MODE_HS = 3'd2;

    function automatic logic is_crystal(input logic [2:0] mode);
        return (mode == MODE_LP) || (mode == MODE_XT) || (mode == MODE_HS);
    endfunction

endpackage

// File: rtl/sleep_clk_sync.sv
module sleep_clk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] shift_d, shift_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb shift_d = d_i;
        end else begin : g_chain
            always_comb shift_d = {shift_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= shift_d;
    end

    assign q_o = shift_q[STAGES-1];
endmodule

// File: rtl/sleep_clk_ost.sv
module sleep_clk_ost #(
    parameter int OST_CYCLES  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_pri,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = $clog2(OST_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(OST_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } ost_regs_t;

    logic      run_s;
    ost_regs_t r_d, r_q;

    sleep_clk_sync #(.STAGES(SYNC_STAGES)) i_run_sync (
        .clk  (clk_pri),
        .rst_n(rst_n),
        .d_i  (run_i),
        .q_o  (run_s)
    );

    always_comb begin
        r_d = r_q;
        if (!run_s) begin
            r_d.cnt  = '0;
            r_d.done = 1'b0;
        end else begin
            if (r_q.cnt != LIMIT) r_d.cnt = r_q.cnt + 1'b1;
            r_d.done = (r_q.cnt == LIMIT);
        end
    end

    always_ff @(posedge clk_pri or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o = r_q.done;

    // R4: the count saturates at its limit
    p_ost_no_overflow_r4: assert property (@(posedge clk_pri) disable iff (!rst_n)
        r_q.cnt <= LIMIT);

    // R4: done is only raised while the run request is seen
    p_ost_done_needs_run_r4: assert property (@(posedge clk_pri) disable iff (!rst_n)
        done_o |-> $past(run_s));
endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
    import sleep_clk_pkg::*;
#(
    parameter int CPU_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_cmd_i,
    input  logic       wake_req_i,
    input  logic       sel_i,
    input  logic [2:0] mode_i,
    input  logic       two_speed_i,
    input  logic       fail_safe_i,
    input  logic       ost_done_i,
    output logic       hold_o,
    output logic       clk_sel_o,
    output logic       stable_o,
    output logic       ost_run_o
);
    localparam int CW = (CPU_CYCLES > 2) ? $clog2(CPU_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CPU_CYCLES - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic          sel;
        logic          xtal;
        logic          bypass;
        logic          hold;
        logic          clk_sel;
        logic          stable;
        logic          ost_run;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;
    logic       cpu_expired;

    assign cpu_expired = (r_q.cnt == LAST);

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_AWAKE, ST_INT_PEND: begin
                if (r_q.state == ST_INT_PEND && ost_done_i) begin
                    r_d.state   = ST_AWAKE;
                    r_d.clk_sel = 1'b0;
                    r_d.stable  = 1'b1;
                end
                if (sleep_cmd_i) begin
                    r_d.state   = ST_ASLEEP;
                    r_d.hold    = 1'b1;
                    r_d.ost_run = 1'b0;
                end
            end
            ST_ASLEEP: begin
                if (wake_req_i) begin
                    r_d.state   = ST_WAKE;
                    r_d.cnt     = '0;
                    r_d.stable  = 1'b0;
                    r_d.sel     = sel_i;
                    r_d.xtal    = is_crystal(mode_i);
                    r_d.bypass  = two_speed_i | fail_safe_i;
                    r_d.ost_run = !sel_i && is_crystal(mode_i);
                end
            end
            ST_WAKE: begin
                if (!cpu_expired) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end else if (r_q.sel) begin
                    r_d.state   = ST_AWAKE;
                    r_d.hold    = 1'b0;
                    r_d.clk_sel = 1'b1;
                end else if (!r_q.xtal) begin
                    r_d.state   = ST_AWAKE;
                    r_d.hold    = 1'b0;
                    r_d.clk_sel = 1'b0;
                    r_d.stable  = 1'b1;
                end else if (r_q.bypass) begin
                    r_d.state   = ST_INT_PEND;
                    r_d.hold    = 1'b0;
                    r_d.clk_sel = 1'b1;
                end else if (ost_done_i) begin
                    r_d.state   = ST_AWAKE;
                    r_d.hold    = 1'b0;
                    r_d.clk_sel = 1'b0;
                    r_d.stable  = 1'b1;
                end
            end
            default: r_d.state = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.state   <= ST_AWAKE;
            r_q.clk_sel <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign hold_o    = r_q.hold;
    assign clk_sel_o = r_q.clk_sel;
    assign stable_o  = r_q.stable;
    assign ost_run_o = r_q.ost_run;

    // R2: a sleep command while awake holds the core in the next cycle
    p_hold_after_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == ST_AWAKE || r_q.state == ST_INT_PEND) && sleep_cmd_i) |=> hold_o);

    // R2: the clock in use does not move while the core is held
    p_clk_frozen_asleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> $stable(clk_sel_o));

    // R3: the CPU timer never runs past its last value
    p_cpu_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LAST);

    // R4: status only reports stable while on the primary clock
    p_stable_only_primary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stable_o |-> !clk_sel_o);

    // R4: a held exit onto a crystal needs the synchronized done flag
    p_exit_waits_ost_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_o) && !clk_sel_o && r_q.xtal && !r_q.sel) |-> $past(ost_done_i));

    // R6: awake on the primary clock implies stable status
    p_primary_awake_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_o && !clk_sel_o) |-> stable_o);

    // R8: a wake request during a running sequence does not restart the timer
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAKE && !cpu_expired && wake_req_i) |=> (r_q.cnt != '0));
endmodule

// File: rtl/sleep_clk_seq.sv
module sleep_clk_seq #(
    parameter int CPU_CYCLES  = 16,
    parameter int OST_CYCLES  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_int,
    input  logic       clk_pri,
    input  logic       rst_n,
    input  logic       sleep_cmd,
    input  logic       wake_req,
    input  logic       clk_sel_bit,
    input  logic [2:0] osc_mode,
    input  logic       two_speed_en,
    input  logic       fail_safe_en,
    output logic       hold_sleep,
    output logic       sys_clk_sel,
    output logic       pri_stable
);
    logic ost_run;
    logic ost_done_pri;
    logic ost_done_int;

    sleep_clk_ctrl #(.CPU_CYCLES(CPU_CYCLES)) i_ctrl (
        .clk        (clk_int),
        .rst_n      (rst_n),
        .sleep_cmd_i(sleep_cmd),
        .wake_req_i (wake_req),
        .sel_i      (clk_sel_bit),
        .mode_i     (osc_mode),
        .two_speed_i(two_speed_en),
        .fail_safe_i(fail_safe_en),
        .ost_done_i (ost_done_int),
        .hold_o     (hold_sleep),
        .clk_sel_o  (sys_clk_sel),
        .stable_o   (pri_stable),
        .ost_run_o  (ost_run)
    );

    sleep_clk_ost #(.OST_CYCLES(OST_CYCLES), .SYNC_STAGES(SYNC_STAGES)) i_ost (
        .clk_pri(clk_pri),
        .rst_n  (rst_n),
        .run_i  (ost_run),
        .done_o (ost_done_pri)
    );

    sleep_clk_sync #(.STAGES(SYNC_STAGES)) i_done_sync (
        .clk  (clk_int),
        .rst_n(rst_n),
        .d_i  (ost_done_pri),
        .q_o  (ost_done_int)
    );
endmodule

// File: tb/test_sleep_clk_seq.sv
`timescale 1ns/1ps
module test_sleep_clk_seq;
    localparam int CPU = 16;
    localparam int OST = 1024;
    localparam int WIN = 8;

    logic       clk_int = 1'b0;
    logic       clk_pri = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_cmd = 1'b0;
    logic       wake_req = 1'b0;
    logic       clk_sel_bit = 1'b1;
    logic [2:0] osc_mode = 3'd0;
    logic       two_speed_en = 1'b0;
    logic       fail_safe_en = 1'b0;
    logic       hold_sleep, sys_clk_sel, pri_stable;

    int checks = 0;
    int errors = 0;
    int pri_cnt = 0;
    logic exp_clk = 1'b1;

    always #10 clk_int = ~clk_int;
    always #15 clk_pri = ~clk_pri;
    always @(posedge clk_pri) pri_cnt <= pri_cnt + 1;

    sleep_clk_seq #(.CPU_CYCLES(CPU), .OST_CYCLES(OST)) i_sleep_clk_seq (
        .clk_int(clk_int), .clk_pri(clk_pri), .rst_n(rst_n),
        .sleep_cmd(sleep_cmd), .wake_req(wake_req), .clk_sel_bit(clk_sel_bit),
        .osc_mode(osc_mode), .two_speed_en(two_speed_en), .fail_safe_en(fail_safe_en),
        .hold_sleep(hold_sleep), .sys_clk_sel(sys_clk_sel), .pri_stable(pri_stable)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // 0: exit on internal at CPU, 1: exit on primary at CPU,
    // 2: held until oscillator count, 3: released early then switch
    function automatic int exp_kind(input logic sel, input logic [2:0] mode,
                                    input logic ts, input logic fs);
        if (sel) return 0;
        if (mode > 3'd2) return 1;
        if (ts || fs) return 3;
        return 2;
    endfunction

    function automatic string kind_req(input int kind);
        case (kind)
            0: return "R3";
            1: return "R6";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic trial(input logic sel, input logic [2:0] mode, input logic ts,
                         input logic fs, input bit rewake, input bit flip);
        int kind, snap, n, k;
        string rq;
        kind = exp_kind(sel, mode, ts, fs);
        rq = kind_req(kind);
        // enter sleep
        sleep_cmd = 1'b1;
        @(negedge clk_int);
        sleep_cmd = 1'b0;
        chk(hold_sleep == 1'b1, "R2", "hold after sleep", int'(hold_sleep), 1);
        clk_sel_bit = sel; osc_mode = mode; two_speed_en = ts; fail_safe_en = fs;
        repeat (12) @(negedge clk_int);
        chk(sys_clk_sel == exp_clk, "R2", "clock kept asleep", int'(sys_clk_sel), int'(exp_clk));
        wake_req = 1'b1;
        @(negedge clk_int);
        wake_req = 1'b0;
        snap = pri_cnt;
        chk(pri_stable == 1'b0, "R7", "stable cleared at wake", int'(pri_stable), 0);
        if (flip) begin
            clk_sel_bit = ~sel; osc_mode = (mode > 3'd2) ? 3'd1 : 3'd5;
            two_speed_en = ~ts; fail_safe_en = 1'b0;
        end
        if (kind != 2) begin
            for (int j = 1; j < CPU; j++) begin
                @(negedge clk_int);
                if (rewake && j == 4) wake_req = 1'b1;
                if (rewake && j == 5) wake_req = 1'b0;
            end
            chk(hold_sleep == 1'b1, rewake ? "R8" : (flip ? "R9" : rq),
                "still held at CPU-1", int'(hold_sleep), 1);
            @(negedge clk_int);
            chk(hold_sleep == 1'b0, rewake ? "R8" : (flip ? "R9" : rq),
                "released at CPU", int'(hold_sleep), 0);
            chk(sys_clk_sel == (kind == 1 ? 1'b0 : 1'b1), flip ? "R9" : rq,
                "clock at exit", int'(sys_clk_sel), kind == 1 ? 0 : 1);
            chk(pri_stable == (kind == 1), rq, "stable at exit", int'(pri_stable),
                kind == 1 ? 1 : 0);
            if (kind == 3) begin
                k = 0;
                while (sys_clk_sel == 1'b1 && k < 5000) begin
                    @(negedge clk_int); k++;
                end
                n = pri_cnt - snap;
                chk(n >= OST && n <= OST + WIN, "R5", "switch edge count", n, OST);
                chk(pri_stable == 1'b1, "R5", "stable after switch", int'(pri_stable), 1);
            end
        end else begin
            k = 0;
            while (hold_sleep == 1'b1 && k < 5000) begin
                @(negedge clk_int); k++;
                if (rewake && k == 4) wake_req = 1'b1;
                if (rewake && k == 5) wake_req = 1'b0;
            end
            n = pri_cnt - snap;
            chk(n >= OST && n <= OST + WIN, flip ? "R9" : "R4", "release edge count", n, OST);
            chk(sys_clk_sel == 1'b0, "R4", "clock at exit", int'(sys_clk_sel), 0);
            chk(pri_stable == 1'b1, "R4", "stable at exit", int'(pri_stable), 1);
        end
        exp_clk = (kind == 0) ? 1'b1 : 1'b0;
        repeat (3) @(negedge clk_int);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk_int);
        rst_n = 1'b1;
        @(negedge clk_int);
        chk(hold_sleep == 1'b0, "R1", "reset hold", int'(hold_sleep), 0);
        chk(sys_clk_sel == 1'b1, "R1", "reset clock", int'(sys_clk_sel), 1);
        chk(pri_stable == 1'b0, "R1", "reset stable", int'(pri_stable), 0);
        // wake while awake has no effect (R8)
        wake_req = 1'b1;
        @(negedge clk_int);
        wake_req = 1'b0;
        repeat (2) @(negedge clk_int);
        chk(hold_sleep == 1'b0, "R8", "wake while awake hold", int'(hold_sleep), 0);
        chk(sys_clk_sel == 1'b1, "R8", "wake while awake clock", int'(sys_clk_sel), 1);
        // directed corners
        trial(1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0);   // R3 on internal
        trial(1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);   // R2 transient: select cleared, clock kept, R4
        trial(1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);   // R5 two-speed
        trial(1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0);   // R5 fail-safe with rewake R8
        trial(1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0);   // R6
        trial(1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1);   // R8 and R9
        trial(1'b0, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1);   // R4 with rewake and R9
        // random mix
        for (int i = 0; i < 20; i++) begin
            trial(1'($urandom), 3'($urandom), 1'($urandom_range(0, 3) == 0),
                  1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule